// File: doc/BRIEF.md
# Sync Polarity and Interlace Detector

This block watches the horizontal and vertical sync inputs of a display input port. Each pin is first brought into the system clock domain. The block then measures, in system clocks, how long the pin stays high and how long it stays low within each full sync period. From those durations it decides whether the sync is positive-going (short high pulse) or negative-going (short low pulse).

It also classifies the incoming timing as interlaced or progressive by comparing consecutive fields. All results are presented as one read-only status byte. Two convenience outputs give both syncs normalised to active-high according to the detected polarity.

A downstream timing generator or mode detector uses the normalised syncs directly. Firmware reads the status byte to learn the input format.

Top module: `sync_polarity_monitor`

## Requirements
- R1: Each sync pin passes through a synchroniser of SYNC_STAGES flops (default 2). Status bit 3 shows the synchronised horizontal level and bit 2 shows the synchronised vertical level, with 1 meaning high and 0 meaning low.
- R2: A sync period runs from one synchronised rising edge to the next. At the end of a period, the polarity flag is set to 0 when the high count is more than THRESH_PCT percent (default 60) of the period. Bit 1 is the horizontal flag and bit 0 is the vertical flag.
- R3: At the end of a period, the polarity flag is set to 1 when the low count is more than THRESH_PCT percent of the period.
- R4: When neither portion is more than THRESH_PCT percent, the flag keeps its previous value. This includes a portion of exactly THRESH_PCT percent.
- R5: A flag changes only at the end of a complete period. The first rising edge after reset only starts a measurement, and a long level that has not yet ended leaves the flag unchanged.
- R6: The high and low counters are CNT_W bits wide and saturate. A period in which either counter reached its maximum is discarded, and the flag is held.
- R7: Leading edges are the rising edges of the normalised syncs. At each vertical leading edge, the interlace flag (bit 4) becomes 1 if either of two things differs from the previous field: the parity of the number of horizontal leading edges in the field, or whether the vertical edge fell in the middle half of the line. Otherwise the flag becomes 0. The flag changes only at vertical leading edges.
- R8: Each normalised output equals the synchronised level when its polarity flag is 1 and the inverted level when its flag is 0.
- R9: Reset clears all flags, counters and history. Status bits 7 to 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync pin, asynchronous |
| vsync_in | input | 1 | Vertical sync pin, asynchronous |
| status_o | output | 8 | {3'b000, interlace, h level, v level, h polarity, v polarity} |
| hsync_norm_o | output | 1 | Horizontal sync normalised to active-high |
| vsync_norm_o | output | 1 | Vertical sync normalised to active-high |

## Verification
The horizontal pin is driven with duty cycles well on either side of the threshold, and with splits of exactly 60/40 and 62/38. This separates strict from inclusive comparison and shows that a balanced 50/50 period holds the flag.

A very long high phase is used twice. Inspected before it ends, it shows that nothing moves mid-period. Once closed with a counter saturated, it separates the discard rule from a plain comparison. The vertical pin receives mirrored duty patterns so that its flag and normalised output are confirmed to be independent.

Finally, line-locked fields of 10 lines and of 10.5 lines distinguish progressive from interlaced timing. A return to 10-line fields shows that the flag clears once the alternation stops.

// File: rtl/spm_pkg.sv
package spm_pkg;

   typedef struct packed {
      logic [2:0] rsvd;
      logic       interlace;
      logic       h_lvl;
      logic       v_lvl;
      logic       h_pol;
      logic       v_pol;
   } spm_status_t;

   // True when part is strictly more than pct percent of total
   function automatic logic share_exceeds(input logic [31:0] part,
                                          input logic [31:0] total,
                                          input int unsigned pct);
      logic [63:0] lhs;
      logic [63:0] rhs;
      lhs = 64'(part) * 64'd100;
      rhs = 64'(total) * 64'(pct);
      return lhs > rhs;
   endfunction

endpackage

// File: rtl/spm_sync.sv
module spm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spm_duty.sv
module spm_duty
   import spm_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int THRESH_PCT = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pol
);

   if (CNT_W < 4 || CNT_W > 24) begin : g_bad_width
      $error("spm_duty: CNT_W out of range 4..24");
   end
   if (THRESH_PCT < 50 || THRESH_PCT > 99) begin : g_bad_thresh
      $error("spm_duty: THRESH_PCT out of range 50..99");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             lvl_d;
   logic             armed;
   logic [CNT_W-1:0] hi_q;
   logic [CNT_W-1:0] lo_q;
   logic             rise;
   logic [31:0]      total;
   logic             hi_dom;
   logic             lo_dom;
   logic             sat;

   assign rise   = lvl & ~lvl_d;
   assign total  = 32'(hi_q) + 32'(lo_q);
   assign hi_dom = share_exceeds(32'(hi_q), total, THRESH_PCT);
   assign lo_dom = share_exceeds(32'(lo_q), total, THRESH_PCT);
   assign sat    = (hi_q == CNT_MAX) || (lo_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d <= 1'b0;
         armed <= 1'b0;
         hi_q  <= '0;
         lo_q  <= '0;
         pol   <= 1'b0;
      end else begin
         lvl_d <= lvl;
         if (rise) begin
            armed <= 1'b1;
            hi_q  <= CNT_ONE;
            lo_q  <= '0;
            if (armed && !sat) begin
               if (hi_dom)      pol <= 1'b0;
               else if (lo_dom) pol <= 1'b1;
            end
         end else if (lvl) begin
            if (hi_q != CNT_MAX) hi_q <= hi_q + CNT_ONE;
         end else begin
            if (lo_q != CNT_MAX) lo_q <= lo_q + CNT_ONE;
         end
      end
   end

   // R5: flag moves only when an armed period closes
   p_pol_at_period_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pol) |-> ($past(rise) && $past(armed)));

   // R4: a balanced period leaves the flag alone
   p_ambiguous_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && armed && !hi_dom && !lo_dom) |=> $stable(pol));

   // R6: a saturated high count stays saturated until the period closes
   p_high_saturates_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_q == CNT_MAX && lvl && !rise) |=> (hi_q == CNT_MAX));

endmodule

// File: rtl/spm_interlace.sv
module spm_interlace #(
   parameter int LINE_W = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic h_lead,
   input  logic v_lead,
   output logic ilace
);

   if (LINE_W < 4) begin : g_bad_line
      $error("spm_interlace: LINE_W must be at least 4");
   end

   localparam int                EXT_W    = LINE_W + 2;
   localparam logic [LINE_W-1:0] LINE_MAX = '1;
   localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

   logic [LINE_W-1:0] pos_q;
   logic [LINE_W-1:0] llen_q;
   logic              par_q;
   logic              have_q;
   logic              par_prev_q;
   logic              mid_prev_q;
   logic [EXT_W-1:0]  pos4;
   logic [EXT_W-1:0]  quarter1;
   logic [EXT_W-1:0]  quarter3;
   logic              mid_now;

   assign pos4     = {pos_q, 2'b00};
   assign quarter1 = {2'b00, llen_q};
   assign quarter3 = {1'b0, llen_q, 1'b0} + {2'b00, llen_q};
   assign mid_now  = (llen_q != '0) && (pos4 >= quarter1) && (pos4 < quarter3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q      <= '0;
         llen_q     <= '0;
         par_q      <= 1'b0;
         have_q     <= 1'b0;
         par_prev_q <= 1'b0;
         mid_prev_q <= 1'b0;
         ilace      <= 1'b0;
      end else begin
         if (h_lead) begin
            pos_q  <= '0;
            llen_q <= (pos_q == LINE_MAX) ? LINE_MAX : pos_q + LINE_ONE;
         end else if (pos_q != LINE_MAX) begin
            pos_q <= pos_q + LINE_ONE;
         end

         if (v_lead) begin
            par_q      <= h_lead;
            have_q     <= 1'b1;
            par_prev_q <= par_q;
            mid_prev_q <= mid_now;
            if (have_q) ilace <= (par_q != par_prev_q) || (mid_now != mid_prev_q);
         end else if (h_lead) begin
            par_q <= ~par_q;
         end
      end
   end

   // R7: the interlace flag only moves on a vertical leading edge
   p_ilace_on_vlead_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ilace) |-> $past(v_lead));

   // R7: interlace needs a previous field to compare with
   p_ilace_needs_history_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ilace |-> have_q);

endmodule

// File: rtl/sync_polarity_monitor.sv
module sync_polarity_monitor
   import spm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 12,
   parameter int THRESH_PCT  = 60,
   parameter int LINE_W      = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hsync_in,
   input  logic       vsync_in,
   output logic [7:0] status_o,
   output logic       hsync_norm_o,
   output logic       vsync_norm_o
);

   localparam int NCH = 2;
   localparam int CH_H = 1;
   localparam int CH_V = 0;

   logic [NCH-1:0] raw;
   logic [NCH-1:0] lvl;
   logic [NCH-1:0] pol;
   logic [NCH-1:0] norm;
   logic [NCH-1:0] norm_d;
   logic [NCH-1:0] lead;
   logic           ilace;
   spm_status_t    status;

   assign raw[CH_H] = hsync_in;
   assign raw[CH_V] = vsync_in;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      spm_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw[ch]),
         .q     (lvl[ch])
      );

      spm_duty #(.CNT_W(CNT_W), .THRESH_PCT(THRESH_PCT)) i_duty (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl   (lvl[ch]),
         .pol   (pol[ch])
      );

      assign norm[ch] = pol[ch] ? lvl[ch] : ~lvl[ch];
      assign lead[ch] = norm[ch] & ~norm_d[ch];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) norm_d <= '0;
      else        norm_d <= norm;
   end

   spm_interlace #(.LINE_W(LINE_W)) i_ilace (
      .clk    (clk),
      .rst_n  (rst_n),
      .h_lead (lead[CH_H]),
      .v_lead (lead[CH_V]),
      .ilace  (ilace)
   );

   always_comb begin
      status.rsvd      = 3'b000;
      status.interlace = ilace;
      status.h_lvl     = lvl[CH_H];
      status.v_lvl     = lvl[CH_V];
      status.h_pol     = pol[CH_H];
      status.v_pol     = pol[CH_V];
   end

   assign status_o     = status;
   assign hsync_norm_o = norm[CH_H];
   assign vsync_norm_o = norm[CH_V];

   // R8: with the flag steady, every level change toggles the normalised output
   p_hnorm_tracks_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(status_o[1]) && !$stable(status_o[3])) |-> (hsync_norm_o != $past(hsync_norm_o)));

   p_vnorm_tracks_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(status_o[0]) && !$stable(status_o[2])) |-> (vsync_norm_o != $past(vsync_norm_o)));

endmodule

// File: tb/test_sync_polarity_monitor.sv
module test_sync_polarity_monitor;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync_in = 1'b0;
   logic       vsync_in = 1'b0;
   logic [7:0] status_o;
   logic       hsync_norm_o;
   logic       vsync_norm_o;

   int vectors = 0;
   int miscompares = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_polarity_monitor i_sync_polarity_monitor (
      .clk          (clk),
      .rst_n        (rst_n),
      .hsync_in     (hsync_in),
      .vsync_in     (vsync_in),
      .status_o     (status_o),
      .hsync_norm_o (hsync_norm_o),
      .vsync_norm_o (vsync_norm_o)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic h_run(input int hi, input int lo, input int n);
      for (int i = 0; i < n; i++) begin
         hsync_in = 1'b1; cyc(hi);
         hsync_in = 1'b0; cyc(lo);
      end
   endtask

   task automatic v_run(input int hi, input int lo, input int n);
      for (int i = 0; i < n; i++) begin
         vsync_in = 1'b1; cyc(hi);
         vsync_in = 1'b0; cyc(lo);
      end
   endtask

   task automatic h_close();
      hsync_in = 1'b1; cyc(4);
   endtask

   task automatic v_close();
      vsync_in = 1'b1; cyc(4);
   endtask

   task automatic do_reset();
      hsync_in = 1'b0; vsync_in = 1'b0;
      rst_n = 1'b0; cyc(3);
      rst_n = 1'b1; cyc(2);
      chk("R9 reset status", status_o, 8'h00);
   endtask

   task automatic t_levels();
      hsync_in = 1'b1; vsync_in = 1'b0; cyc(4);
      chk("R1 h high v low", {6'b0, status_o[3:2]}, 8'h02);
      hsync_in = 1'b0; vsync_in = 1'b1; cyc(4);
      chk("R1 h low v high", {6'b0, status_o[3:2]}, 8'h01);
      vsync_in = 1'b0; cyc(4);
      chk("R9 reserved bits", {5'b0, status_o[7:5]}, 8'h00);
   endtask

   task automatic t_h_high_dominant();
      h_run(30, 10, 3); h_close();
      chk("R2 h 75% high", {7'b0, status_o[1]}, 8'h00);
   endtask

   task automatic t_h_low_dominant();
      h_run(10, 30, 3); h_close();
      chk("R3 h 75% low", {7'b0, status_o[1]}, 8'h01);
   endtask

   task automatic t_h_balanced();
      h_run(20, 20, 3); h_close();
      chk("R4 h 50/50 holds", {7'b0, status_o[1]}, 8'h01);
   endtask

   task automatic t_h_mid_period();
      cyc(200);
      chk("R5 open long high keeps flag", {7'b0, status_o[1]}, 8'h01);
      hsync_in = 1'b0; cyc(10); h_close();
      chk("R5 flag after period closes", {7'b0, status_o[1]}, 8'h00);
   endtask

   task automatic t_h_exact_threshold();
      h_run(20, 30, 3); h_close();
      chk("R4 exactly 60% low holds", {7'b0, status_o[1]}, 8'h00);
      h_run(19, 31, 3); h_close();
      chk("R3 62% low", {7'b0, status_o[1]}, 8'h01);
   endtask

   task automatic t_h_saturation();
      cyc(5000);
      hsync_in = 1'b0; cyc(10); h_close();
      chk("R6 saturated period discarded", {7'b0, status_o[1]}, 8'h01);
      h_run(31, 19, 3); h_close();
      chk("R2 62% high", {7'b0, status_o[1]}, 8'h00);
   endtask

   task automatic t_h_norm();
      chk("R8 h flag 0, level 1 -> norm 0", {7'b0, hsync_norm_o}, 8'h00);
      hsync_in = 1'b0; cyc(4);
      chk("R8 h flag 0, level 0 -> norm 1", {7'b0, hsync_norm_o}, 8'h01);
   endtask

   task automatic t_v_polarity();
      v_run(10, 40, 3); v_close();
      chk("R3 v 80% low", {7'b0, status_o[0]}, 8'h01);
      chk("R8 v flag 1, level 1 -> norm 1", {7'b0, vsync_norm_o}, 8'h01);
      v_run(40, 10, 3); v_close();
      chk("R2 v 80% high", {7'b0, status_o[0]}, 8'h00);
      chk("R8 v flag 0, level 1 -> norm 0", {7'b0, vsync_norm_o}, 8'h00);
      chk("R2 h flag unaffected by v", {7'b0, status_o[1]}, 8'h00);
      vsync_in = 1'b0; cyc(4);
   endtask

   task automatic run_fields(input int field_len, input int fields);
      int lines;
      lines = (field_len * fields) / 40;
      fork
         begin
            for (int i = 0; i < lines; i++) begin
               hsync_in = 1'b1; cyc(4);
               hsync_in = 1'b0; cyc(36);
            end
         end
         begin
            for (int i = 0; i < fields; i++) begin
               vsync_in = 1'b1; cyc(8);
               vsync_in = 1'b0; cyc(field_len - 8);
            end
         end
      join
      cyc(4);
   endtask

   task automatic t_interlace();
      do_reset();
      run_fields(400, 12);
      chk("R7 progressive 10-line fields", {7'b0, status_o[4]}, 8'h00);
      chk("R3 h and v positive pulses", {6'b0, status_o[1:0]}, 8'h03);
      run_fields(420, 12);
      chk("R7 interlaced 10.5-line fields", {7'b0, status_o[4]}, 8'h01);
      run_fields(400, 12);
      chk("R7 back to progressive", {7'b0, status_o[4]}, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      do_reset();
      t_levels();
      t_h_high_dominant();
      t_h_low_dominant();
      t_h_balanced();
      t_h_mid_period();
      t_h_exact_threshold();
      t_h_saturation();
      t_h_norm();
      t_v_polarity();
      t_interlace();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule